// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block turns the synchronized input levels of one GPIO bank (32 pins by default) into a single interrupt request. For each pin, software picks one of five trigger conditions: rising edge, falling edge, either edge, high level or low level. The choice is made with three per-pin configuration bits: edge mode, polarity and both-edges. Every detected event sets a sticky status bit. Software clears a status bit by writing 1 to it.

A mask register decides which status bits can raise the combined interrupt output. Software never writes the mask directly. Writing ones to an unmask strobe register clears mask bits, and writing ones to a mask strobe register sets them. Writing all ones to the mask strobe register silences the whole bank in one write. The register bus is a simple single-cycle write port with a combinational read port, addressed by word index.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, the mask register reads all ones. The status, edge-mode, polarity and both-edges registers read zero, and irq_out is 0.
- R2: When a pin has edge-mode bit 1 and both-edges bit 0, its status bit sets on the clock edge at which the pin differs from its value one cycle earlier. With polarity 1 only a 0-to-1 change counts, and with polarity 0 only a 1-to-0 change counts. The status bit sets whether or not the pin is masked.
- R3: When a pin has edge-mode bit 1 and both-edges bit 1, a change in either direction sets its status bit, and the polarity bit is ignored.
- R4: When a pin has edge-mode bit 0, it is level triggered: polarity 1 is active high and polarity 0 is active low. The status bit is set again on every cycle that the active level is present, so a clear has no lasting effect while that level holds. The both-edges bit has no effect in this mode.
- R5: Writing a 1 to a status bit clears it. Writing a 0 to a status bit leaves it unchanged.
- R6: Writing 1 to a bit of the unmask strobe register (index 1) clears that mask bit. Writing 1 to a bit of the mask strobe register (index 2) sets that mask bit. Zero bits in either write change nothing. A write to the mask register (index 0) is ignored. Both strobe registers read zero.
- R7: irq_out is 1 exactly when some status bit is 1 and its mask bit is 0. It follows register changes in the same cycle they become visible on a read.
- R8: Writing all ones to the mask strobe register masks every pin at once, and irq_out drops to 0 while status is kept.
- R9: If a new event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R10: The register word indexes are: 0 mask, 1 unmask strobe, 2 mask strobe, 3 status, 4 edge mode, 5 polarity, 6 both-edges. Index 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | W | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A wrong mask bit shows on irq_out in the same cycle the status bit appears. A reading of the mask register shows it at once. A wrong stored previous pin level shows as a missing or extra status bit one clock after the pin changes. A wrongly decoded configuration bit shows the same way, only for the pins that use it. A lost clear shows as a status bit still set on the read just after the write. The bench follows every write and pin change with register reads of status and mask and a check of irq_out, so such faults show up within two cycles of their cause.

// File: rtl/gbi_pkg.sv
package gbi_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_MASK   = 3'd0,
        REG_UNMASK = 3'd1,
        REG_DOMASK = 3'd2,
        REG_STATUS = 3'd3,
        REG_EMODE  = 3'd4,
        REG_POL    = 3'd5,
        REG_BOTH   = 3'd6
    } gbi_reg_e;

    typedef struct packed {
        logic is_edge;
        logic pol_hi;
        logic both;
    } gbi_pin_cfg_t;

    // Trigger decision for one pin given its current and previous level.
    function automatic logic gbi_event(input gbi_pin_cfg_t c,
                                       input logic now_v,
                                       input logic was_v);
        logic ev;
        if (c.is_edge) begin
            if (c.both)
                ev = now_v ^ was_v;
            else if (c.pol_hi)
                ev = now_v & ~was_v;
            else
                ev = ~now_v & was_v;
        end else begin
            ev = c.pol_hi ? now_v : ~now_v;
        end
        return ev;
    endfunction
endpackage

// File: rtl/gbi_regs.sv
module gbi_regs
    import gbi_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      emode_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      both_q,
    output logic [W-1:0]      mask_q,
    output logic [W-1:0]      sts_clr
);
    logic wr_unmask, wr_domask;

    always_comb begin
        wr_unmask = bus_wr && (bus_addr == REG_UNMASK);
        wr_domask = bus_wr && (bus_addr == REG_DOMASK);
        sts_clr   = (bus_wr && (bus_addr == REG_STATUS)) ? bus_wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            emode_q <= '0;
            pol_q   <= '0;
            both_q  <= '0;
            mask_q  <= '1;
        end else begin
            if (bus_wr && bus_addr == REG_EMODE) emode_q <= bus_wdata;
            if (bus_wr && bus_addr == REG_POL)   pol_q   <= bus_wdata;
            if (bus_wr && bus_addr == REG_BOTH)  both_q  <= bus_wdata;
            if (wr_unmask)
                mask_q <= mask_q & ~bus_wdata;
            else if (wr_domask)
                mask_q <= mask_q | bus_wdata;
        end
    end
endmodule

// File: rtl/gbi_detect.sv
module gbi_detect
    import gbi_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] emode_q,
    input  logic [W-1:0] pol_q,
    input  logic [W-1:0] both_q,
    output logic [W-1:0] evt
);
    logic [W-1:0] pin_prev;

    // Previous level tracks the pins even in reset, so no false edge follows reset.
    always_ff @(posedge clk) begin
        pin_prev <= pin_in;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        gbi_pin_cfg_t cfg;
        always_comb begin
            cfg.is_edge = emode_q[i];
            cfg.pol_hi  = pol_q[i];
            cfg.both    = both_q[i];
            evt[i]      = gbi_event(cfg, pin_in[i], pin_prev[i]);
        end
    end
endmodule

// File: rtl/gbi_status.sv
module gbi_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] sts_clr,
    input  logic [W-1:0] mask_q,
    output logic [W-1:0] status_q,
    output logic         irq_out
);
    always_ff @(posedge clk) begin
        if (rst)
            status_q <= '0;
        else
            status_q <= (status_q & ~sts_clr) | evt;
    end

    always_comb irq_out = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gbi_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      pin_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq_out
);
    logic [W-1:0] emode_q, pol_q, both_q, mask_q, sts_clr, evt, status_q;

    gbi_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .emode_q(emode_q), .pol_q(pol_q),
        .both_q(both_q), .mask_q(mask_q), .sts_clr(sts_clr)
    );

    gbi_detect #(.W(W)) u_detect (
        .clk(clk), .pin_in(pin_in), .emode_q(emode_q), .pol_q(pol_q),
        .both_q(both_q), .evt(evt)
    );

    gbi_status #(.W(W)) u_status (
        .clk(clk), .rst(rst), .evt(evt), .sts_clr(sts_clr),
        .mask_q(mask_q), .status_q(status_q), .irq_out(irq_out)
    );

    always_comb begin
        case (bus_addr)
            REG_MASK:   bus_rdata = mask_q;
            REG_STATUS: bus_rdata = status_q;
            REG_EMODE:  bus_rdata = emode_q;
            REG_POL:    bus_rdata = pol_q;
            REG_BOTH:   bus_rdata = both_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gbi_checker.sv
module gbi_checker
    import gbi_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      status_q,
    input logic [W-1:0]      mask_q,
    input logic              irq_out
);
    // R1: first cycle after reset has everything masked and no status
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_q) && (status_q == '0));

    // R6: unmask strobe clears every written-1 bit
    a_r6_unmask_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_UNMASK) |=> ((mask_q & $past(bus_wdata)) == '0));

    // R6: mask strobe sets every written-1 bit
    a_r6_domask_sets: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DOMASK) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R5: without a status write no status bit ever falls
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == REG_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R8: fully masked bank never requests
    a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |-> !irq_out);

    // R6: writes to the mask register itself leave it unchanged
    a_r6_mask_readonly: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_MASK) |=> $stable(mask_q));
endmodule

bind gpio_bank_irq gbi_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .status_q(status_q), .mask_q(mask_q),
    .irq_out(irq_out)
);

// File: tb/gpio_bank_irq_test.sv
module gpio_bank_irq_test;
    localparam int W = 32;
    localparam logic [2:0] A_MASK = 3'd0, A_UNM = 3'd1, A_DOM = 3'd2,
                           A_STS = 3'd3, A_EMD = 3'd4, A_POL = 3'd5,
                           A_BOTH = 3'd6, A_NONE = 3'd7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] pins = '1;
    logic bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic irq_out;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [W-1:0] exp;
        bit           chk_irq;
        bit           exp_irq;
        string        tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    gpio_bank_irq #(.W(W)) uut (
        .clk(clk), .rst(rst), .pin_in(pins), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // Monitor: compares expected items after the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_run++;
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
                end
                if (it.chk_irq) begin
                    n_run++;
                    if (irq_out !== it.exp_irq) begin
                        n_fail++;
                        $display("FAIL %s: irq_out=%0b expected=%0b", it.tag, irq_out, it.exp_irq);
                    end
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic setpin(input int i, input logic v);
        @(negedge clk);
        pins[i] = v;
        @(negedge clk);
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [W-1:0] e,
                             input bit ci, input bit ei, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        it.exp = e; it.chk_irq = ci; it.exp_irq = ei; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
        #3;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        expect_rd(A_MASK, '1, 1, 0, "R1 mask");
        expect_rd(A_STS, '0, 1, 0, "R1 status");
        expect_rd(A_EMD, '0, 0, 0, "R1 edge mode");
        expect_rd(A_POL, '0, 0, 0, "R1 polarity");
        expect_rd(A_BOTH, '0, 0, 0, "R1 both-edges");
        // R10 unused index and strobe reads
        expect_rd(A_NONE, '0, 0, 0, "R10 unused index");
        expect_rd(A_UNM, '0, 0, 0, "R10 unmask strobe reads 0");

        // R6 mask strobes
        wr(A_UNM, 32'h0000_00F1);
        expect_rd(A_MASK, 32'hFFFF_FF0E, 1, 0, "R6 unmask");
        wr(A_UNM, 32'h0);
        expect_rd(A_MASK, 32'hFFFF_FF0E, 0, 0, "R6 unmask zero write");
        wr(A_DOM, 32'h0000_0010);
        expect_rd(A_MASK, 32'hFFFF_FF1E, 0, 0, "R6 mask strobe");
        wr(A_MASK, 32'h0);
        expect_rd(A_MASK, 32'hFFFF_FF1E, 0, 0, "R6 direct mask write ignored");
        expect_rd(A_DOM, '0, 0, 0, "R6 mask strobe reads 0");

        // configure pins 0..2 as edge, pin0 rising, pin1 falling, pin2 both
        wr(A_EMD, 32'h7);
        wr(A_POL, 32'h5);
        wr(A_BOTH, 32'h4);
        expect_rd(A_STS, '0, 1, 0, "R2 no event on config");

        // R2 rising on pin0
        setpin(0, 1'b0);
        expect_rd(A_STS, '0, 1, 0, "R2 falling ignored on rising pin");
        setpin(0, 1'b1);
        expect_rd(A_STS, 32'h1, 1, 1, "R2 rising sets status");

        // R5 clear
        wr(A_STS, 32'h0);
        expect_rd(A_STS, 32'h1, 1, 1, "R5 zero write keeps");
        wr(A_STS, 32'h1);
        expect_rd(A_STS, 32'h0, 1, 0, "R5 one write clears");

        // R2 falling on pin1, masked pin still latches
        setpin(1, 1'b0);
        expect_rd(A_STS, 32'h2, 1, 0, "R2 falling sets masked pin");
        setpin(1, 1'b1);
        expect_rd(A_STS, 32'h2, 0, 0, "R2 rising ignored on falling pin");
        wr(A_STS, 32'h2);

        // R3 both edges on pin2 (polarity 1 ignored)
        setpin(2, 1'b0);
        expect_rd(A_STS, 32'h4, 1, 0, "R3 falling with both-edges");
        wr(A_STS, 32'h4);
        expect_rd(A_STS, 32'h0, 0, 0, "R3 cleared");
        setpin(2, 1'b1);
        expect_rd(A_STS, 32'h4, 0, 0, "R3 rising with both-edges");
        wr(A_STS, 32'h4);

        // R4 level high on pin3
        wr(A_POL, 32'h0D);
        expect_rd(A_STS, 32'h8, 0, 0, "R4 level high sets");
        wr(A_STS, 32'h8);
        expect_rd(A_STS, 32'h8, 0, 0, "R4 clear while level active");
        setpin(3, 1'b0);
        wr(A_STS, 32'h8);
        expect_rd(A_STS, 32'h0, 0, 0, "R4 clear after level removed");

        // R4 level low on pin5 (default config)
        setpin(5, 1'b0);
        expect_rd(A_STS, 32'h20, 0, 0, "R4 level low sets");
        setpin(5, 1'b1);
        wr(A_STS, 32'h20);
        expect_rd(A_STS, 32'h0, 0, 0, "R4 level low cleared");

        // R4 both-edges ignored in level mode (pin4)
        wr(A_BOTH, 32'h14);
        wr(A_POL, 32'h1D);
        expect_rd(A_STS, 32'h10, 0, 0, "R4 pin4 level high");
        setpin(4, 1'b0);
        wr(A_STS, 32'h10);
        expect_rd(A_STS, 32'h0, 0, 0, "R4 pin4 low, no edge event");
        setpin(4, 1'b1);
        wr(A_STS, 32'h10);
        expect_rd(A_STS, 32'h10, 0, 0, "R4 both-edges ignored, stays level");
        setpin(4, 1'b0);
        wr(A_STS, 32'h10);
        expect_rd(A_STS, 32'h0, 1, 0, "R4 pin4 idle");

        // R7 / R8 output and global mask
        setpin(0, 1'b0);
        setpin(0, 1'b1);
        expect_rd(A_STS, 32'h1, 1, 1, "R7 unmasked status drives irq");
        wr(A_DOM, 32'hFFFF_FFFF);
        expect_rd(A_MASK, 32'hFFFF_FFFF, 1, 0, "R8 mask all silences irq");
        expect_rd(A_STS, 32'h1, 1, 0, "R8 status kept while masked");
        wr(A_UNM, 32'h1);
        expect_rd(A_MASK, 32'hFFFF_FFFE, 1, 1, "R7 unmask restores irq");

        // R9 event wins over simultaneous clear
        wr(A_STS, 32'h1);
        expect_rd(A_STS, 32'h0, 1, 0, "R9 precondition cleared");
        setpin(0, 1'b0);
        @(negedge clk);
        pins[0] = 1'b1;
        bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        expect_rd(A_STS, 32'h1, 1, 1, "R9 event beats clear");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule